// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block is the timing core of a master for a bus that has one shared, open-drain data line and no clock line. Every bit is carried by how long the master holds the line low. A host hands the block one command at a time: a bus reset, a one-bit write or a one-bit read. The block pulls the line low or lets it float for exactly the number of microseconds each phase needs. A prescaler that counts system clocks produces the microsecond steps.

A reset holds the line low for a long interval and then listens. During the listening window a device announces itself by pulling the line low, and the block records this as a presence flag. A write keeps the line low for a short time to send a one and for the whole slot to send a zero. A read pulls the line low briefly, releases it, and samples the line a little later. The pad is modelled as a pull-low enable output and a line input. The line input passes through a two-flop synchroniser before any sampling. The host sees a busy level and a one-cycle done pulse for each command.

Top module: `swbus_master`

## Requirements
- R1: After reset, `line_pull_low`, `busy`, `done`, `presence` and `rd_bit` are all 0.
- R2: `cmd_op` encodes 2'b01 = bus reset, 2'b10 = write of `cmd_wbit`, 2'b11 = read, and 2'b00 = no operation. A command is accepted on a clock edge where `cmd_valid` is 1, `busy` is 0 and `cmd_op` is not 2'b00. `busy` is 1 from the next cycle on, and every operation begins with the line pulled low.
- R3: A bus reset pulls the line low for RST_LOW_US (480) microseconds from its first busy cycle, releases it, and keeps `busy` high for a further RST_LISTEN_US (480) microseconds.
- R4: `presence` takes the inverse of the synchronised line level sampled PRES_AT_US (70) microseconds after the reset release: low means a device answered (1). Only a bus reset changes `presence`.
- R5: A write of 1 pulls the line low for W1_LOW_US (6) microseconds and then leaves it released until the operation ends.
- R6: A write of 0 pulls the line low for SLOT_US (60) microseconds. Every write and read lasts SLOT_US + RECOVER_US (62) microseconds, and the line is released during the final RECOVER_US microseconds.
- R7: A read pulls the line low for RD_LOW_US (2) microseconds and samples the synchronised line RD_AT_US (13) microseconds after the start. `rd_bit` becomes 0 for a low sample and 1 for a high sample. Only a read changes `rd_bit`.
- R8: `done` is 1 for exactly one cycle, which is the first cycle in which `busy` is 0 again after an operation.
- R9: Commands presented while `busy` is 1 are ignored, and the running operation keeps its timing.
- R10: One microsecond is CLKS_PER_US clocks, counted from the acceptance edge. The line value used by a sample taken at a clock edge is the one present two edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_wbit | input | 1 | Bit value for a write |
| line_in | input | 1 | Level seen on the bus line |
| line_pull_low | output | 1 | 1 = pull the bus line low, 0 = release it |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| presence | output | 1 | A device answered the last bus reset |
| rd_bit | output | 1 | Value of the last read |

## Verification
The hardest case to reach from the ports is the line level that lands exactly on the sample edge. Behind the two-flop synchroniser, it decides whether a read returns 0 or 1. The bench models a device that holds the line low over a window counted in clocks from the acceptance edge. It moves the end of that window by a single clock across the read sample point, so that one run must return 0 and the next must return 1. To show that commands arriving mid-operation are ignored, the bench injects a read command into the middle of a write-0 slot. It then measures the full pulled-low time and confirms that `rd_bit` is unchanged.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } swbus_op_e;

  typedef struct packed {
    swbus_op_e op;
    logic      wbit;
  } swbus_cmd_t;

endpackage

// File: rtl/swbus_prescale.sv
module swbus_prescale #(
  parameter int CLKS_PER_US = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (CLKS_PER_US <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int PW = $clog2(CLKS_PER_US);
      localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + PW'(1);
      end

      assign tick = run && (cnt_q == LAST);

      // R10: ticks are at least two clocks apart when a microsecond spans several clocks
      a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/swbus_sync.sv
module swbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  generate
    genvar s;
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b1;
          else        sh_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[s] <= 1'b1;
          else        sh_q[s] <= sh_q[s-1];
        end
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/swbus_seq.sv
module swbus_seq
  import swbus_pkg::*;
#(
  parameter int RST_LOW_US    = 480,
  parameter int RST_LISTEN_US = 480,
  parameter int PRES_AT_US    = 70,
  parameter int SLOT_US       = 60,
  parameter int RECOVER_US    = 2,
  parameter int W1_LOW_US     = 6,
  parameter int RD_LOW_US     = 2,
  parameter int RD_AT_US      = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  swbus_cmd_t cmd,
  input  logic       tick,
  input  logic       line_s,
  output logic       busy,
  output logic       done,
  output logic       drive_low,
  output logic       presence,
  output logic       rd_bit
);

  localparam int MAX_US = RST_LOW_US + RST_LISTEN_US + SLOT_US + RECOVER_US;
  localparam int CW     = $clog2(MAX_US + 1);

  function automatic logic [CW-1:0] f_low_us(swbus_op_e op, logic wb);
    case (op)
      OP_RESET: return CW'(RST_LOW_US);
      OP_WRITE: return wb ? CW'(W1_LOW_US) : CW'(SLOT_US);
      OP_READ:  return CW'(RD_LOW_US);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [CW-1:0] f_total_us(swbus_op_e op);
    if (op == OP_RESET) return CW'(RST_LOW_US + RST_LISTEN_US);
    return CW'(SLOT_US + RECOVER_US);
  endfunction

  function automatic logic [CW-1:0] f_sample_us(swbus_op_e op);
    case (op)
      OP_RESET: return CW'(RST_LOW_US + PRES_AT_US);
      OP_READ:  return CW'(RD_AT_US);
      default:  return '0;
    endcase
  endfunction

  logic          busy_q, done_q, pres_q, rd_q;
  swbus_op_e     op_q;
  logic          wbit_q;
  logic [CW-1:0] us_q;

  logic          accept, at_end, at_sample, pres_capture, rd_capture;
  logic [CW-1:0] low_us, total_us, sample_us;

  assign low_us    = f_low_us(op_q, wbit_q);
  assign total_us  = f_total_us(op_q);
  assign sample_us = f_sample_us(op_q);

  assign accept       = start && !busy_q && (cmd.op != OP_NOP);
  assign at_end       = busy_q && tick && (us_q == total_us - CW'(1));
  assign at_sample    = busy_q && tick && (sample_us != '0) && (us_q == sample_us - CW'(1));
  assign pres_capture = at_sample && (op_q == OP_RESET);
  assign rd_capture   = at_sample && (op_q == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NOP;
      wbit_q <= 1'b0;
      us_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= cmd.op;
      wbit_q <= cmd.wbit;
      us_q   <= '0;
    end else if (busy_q) begin
      if (tick)   us_q   <= us_q + CW'(1);
      if (at_end) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pres_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      done_q <= at_end;
      if (pres_capture) pres_q <= !line_s;
      if (rd_capture)   rd_q   <= line_s;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign presence  = pres_q;
  assign rd_bit    = rd_q;
  assign drive_low = busy_q && (us_q < low_us);

  // R8: the done pulse marks the first idle cycle after an operation
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9: the microsecond count never restarts inside a running operation
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (us_q >= $past(us_q)));

  // R7: the read result only moves at a read sample point
  a_r7_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rd_bit));

  // R4: the presence flag only moves at a reset sample point
  a_r4_pres_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_capture |=> $stable(presence));

  // R3: the line is pulled low only inside an operation
  a_r3_low_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> busy);

endmodule

// File: rtl/swbus_master.sv
module swbus_master
  import swbus_pkg::*;
#(
  parameter int CLKS_PER_US   = 250,
  parameter int SYNC_STAGES   = 2,
  parameter int RST_LOW_US    = 480,
  parameter int RST_LISTEN_US = 480,
  parameter int PRES_AT_US    = 70,
  parameter int SLOT_US       = 60,
  parameter int RECOVER_US    = 2,
  parameter int W1_LOW_US     = 6,
  parameter int RD_LOW_US     = 2,
  parameter int RD_AT_US      = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic       line_in,
  output logic       line_pull_low,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rd_bit
);

  swbus_cmd_t cmd;
  logic       us_tick;
  logic       line_s;
  logic       busy_w;

  assign cmd.op   = swbus_op_e'(cmd_op);
  assign cmd.wbit = cmd_wbit;

  swbus_prescale #(
    .CLKS_PER_US(CLKS_PER_US)
  ) u_prescale (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_w),
    .tick (us_tick)
  );

  swbus_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (line_in),
    .q    (line_s)
  );

  swbus_seq #(
    .RST_LOW_US   (RST_LOW_US),
    .RST_LISTEN_US(RST_LISTEN_US),
    .PRES_AT_US   (PRES_AT_US),
    .SLOT_US      (SLOT_US),
    .RECOVER_US   (RECOVER_US),
    .W1_LOW_US    (W1_LOW_US),
    .RD_LOW_US    (RD_LOW_US),
    .RD_AT_US     (RD_AT_US)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_valid),
    .cmd      (cmd),
    .tick     (us_tick),
    .line_s   (line_s),
    .busy     (busy_w),
    .done     (done),
    .drive_low(line_pull_low),
    .presence (presence),
    .rd_bit   (rd_bit)
  );

  assign busy = busy_w;

  // R2: every operation opens with the line pulled low
  a_r2_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_pull_low);

endmodule

// File: tb/test_swbus_master.sv
`timescale 1ns/1ps
module test_swbus_master;

  localparam int C = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       cmd_wbit = 1'b0;
  logic       dev_low = 1'b0;
  logic       line_in;
  logic       line_pull_low, busy, done, presence, rd_bit;

  assign line_in = !(line_pull_low || dev_low);

  always #2 clk = ~clk;

  swbus_master #(.CLKS_PER_US(C)) i_swbus_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wbit(cmd_wbit), .line_in(line_in), .line_pull_low(line_pull_low),
    .busy(busy), .done(done), .presence(presence), .rd_bit(rd_bit));

  int checks = 0;
  int errors = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // durations in clocks, stated from the requirements
  function automatic int low_cyc(logic [1:0] op, bit wb);
    if (op == 2'b01) return 480 * C;
    if (op == 2'b10) return wb ? 6 * C : 60 * C;
    return 2 * C;
  endfunction
  function automatic int total_cyc(logic [1:0] op);
    return (op == 2'b01) ? 960 * C : 62 * C;
  endfunction
  function automatic int samp_cyc(logic [1:0] op);
    if (op == 2'b01) return 550 * C;
    if (op == 2'b11) return 13 * C;
    return -1;
  endfunction

  // behavioural reference, advanced once per edge and compared at the negedge
  bit         m_busy, m_done, m_pres, m_rd, m_wb, sy;
  int         m_k;
  logic [1:0] m_op;
  bit         hist[$];
  bit         rec_rst, rec_cv, rec_wb, rec_line;
  logic [1:0] rec_op;

  always @(negedge clk) begin
    if (!rec_rst) begin
      m_busy = 0; m_done = 0; m_pres = 0; m_rd = 0; m_k = 0; m_op = 2'b00; m_wb = 0;
      hist = {1'b1, 1'b1};
    end else begin
      sy = hist[hist.size() - 2];
      hist.push_back(rec_line);
      if (hist.size() > 4) void'(hist.pop_front());
      m_done = 0;
      if (m_busy) begin
        m_k++;
        if (m_k == samp_cyc(m_op) && m_op == 2'b01) m_pres = !sy;
        if (m_k == samp_cyc(m_op) && m_op == 2'b11) m_rd = sy;
        if (m_k == total_cyc(m_op)) begin m_busy = 0; m_done = 1; end
      end else if (rec_cv && rec_op != 2'b00) begin
        m_busy = 1; m_k = 0; m_op = rec_op; m_wb = rec_wb;
      end
    end
    check("R3 R5 R6 line_pull_low", line_pull_low, int'(m_busy && m_k < low_cyc(m_op, m_wb)));
    check("R2 R9 busy", busy, m_busy);
    check("R8 done", done, m_done);
    check("R4 R10 presence", presence, m_pres);
    check("R7 R10 rd_bit", rd_bit, m_rd);
    rec_rst = rst_n; rec_cv = cmd_valid; rec_op = cmd_op; rec_wb = cmd_wbit; rec_line = line_in;
  end

  // device pulls low for clocks [dfrom, dto) after the acceptance edge
  task automatic run_op(logic [1:0] op, bit wb, int dfrom, int dto, int inj_k, output int lowcnt);
    int k;
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = op; cmd_wbit = wb;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_op = 2'b00;
    k = 0; lowcnt = 0;
    forever begin
      @(negedge clk);
      if (line_pull_low) lowcnt++;
      if (done) break;
      @(posedge clk); #1;
      k++;
      dev_low = (k >= dfrom && k < dto);
      cmd_valid = (k == inj_k); cmd_op = (k == inj_k) ? 2'b11 : 2'b00;
    end
    dev_low = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int lc;
    int rd_before;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", {line_pull_low, busy, done, presence, rd_bit}, 0);
    @(posedge clk); #1 rst_n = 1;

    // R4: device answers 15..135 us after release, covering the 70 us point
    run_op(2'b01, 0, (480 + 15) * C, (480 + 135) * C, -1, lc);
    check("R3 reset low time", lc, 480 * C);
    check("R4 presence seen", presence, 1);
    // R4: nobody answers
    run_op(2'b01, 0, 0, 0, -1, lc);
    check("R4 presence absent", presence, 0);
    // R4: short answer 15..75 us still covers the sample
    run_op(2'b01, 0, (480 + 15) * C, (480 + 75) * C, -1, lc);
    check("R4 short presence", presence, 1);

    run_op(2'b10, 1, 0, 0, -1, lc);
    check("R5 write-1 low time", lc, 6 * C);
    run_op(2'b10, 0, 0, 0, -1, lc);
    check("R6 write-0 low time", lc, 60 * C);

    run_op(2'b11, 0, 1, 15 * C, -1, lc);
    check("R7 read low time", lc, 2 * C);
    check("R7 read zero", rd_bit, 0);
    run_op(2'b11, 0, 0, 0, -1, lc);
    check("R7 read one", rd_bit, 1);
    check("R4 presence kept by reads", presence, 1);

    // R10: sample at edge 13C uses the line two edges earlier
    run_op(2'b11, 0, 1, 13 * C - 2, -1, lc);
    check("R10 late release reads zero", rd_bit, 0);
    run_op(2'b11, 0, 1, 13 * C - 3, -1, lc);
    check("R10 early release reads one", rd_bit, 1);

    // R9: read injected into a write-0 slot
    rd_before = rd_bit;
    run_op(2'b10, 0, 0, 0, 10, lc);
    check("R9 slot unaffected", lc, 60 * C);
    check("R9 rd_bit unaffected", rd_bit, rd_before);

    // R2: no-operation code is not accepted
    @(posedge clk); #1 cmd_valid = 1; cmd_op = 2'b00;
    @(posedge clk); #1 cmd_valid = 0;
    @(negedge clk);
    check("R2 nop ignored", busy, 0);

    repeat (3) @(posedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule